// File: doc/BRIEF.md
# Programmable SPI Master with Boot Preset

This block is an SPI master that runs from the core clock. When it is told to start, it pulls one of three chip-select lines low. It waits a programmed number of core cycles and then clocks a programmed number of bytes out on MOSI, most significant bit first. At the same time it collects the bytes arriving on MISO. The clock polarity and the phase can be chosen independently of each other. The SCK rate is the core clock divided by a power of two.

The host drives a start pulse and then watches `busy` and `done`. It supplies transmit bytes one at a time. A `txTake` pulse tells the host that the current byte has been consumed, so it can present the next one. Each received byte appears on `rxByte`, together with a single-cycle `rxValid`.

A boot input replaces all the user timing settings with a fixed preset for reading a serial EEPROM on the configuration select line. With the preset, only the byte count still comes from the host.

Top module: `spi_xfer_master`

## Requirements
- R1: The SCK half period is 2^(E-1) core cycles. E is `divExp` clamped to the range 3..14, so the full SCK period runs from 8 to 16384 core cycles.
- R2: The first SCK edge comes exactly S core cycles after the chip select falls. S is `setupCyc` clamped to the range 16..48.
- R3: Outside a transfer, SCK rests at the CPOL level. With CPHA=0, MISO is sampled on the leading edge of each bit and MOSI changes on the trailing edge. With CPHA=1 the two roles swap.
- R4: A transfer moves `byteCount`+1 bytes, MSB first, which means 16 SCK edges per byte. `txByte` is captured when the start is accepted and again at each byte boundary, and every capture is followed one cycle later by a one-cycle `txTake` pulse.
- R5: After every 8th sampling edge, the byte received (first bit in the MSB) appears on `rxByte` with a one-cycle `rxValid`.
- R6: `csSel` values select the line: 0 drives `csN[0]`, 1 drives `csN[1]`, and 2 or 3 drive `csN[2]` (configuration). All lines are high (inactive) outside a transfer, and at most one line is ever low.
- R7: After the last SCK edge, the chip select stays low for exactly one SCK half period before it rises.
- R8: After the chip select rises, at least 2 core cycles pass before any chip select falls again. `done` pulses for one cycle in the cycle where `busy` has just dropped.
- R9: While `bootMode` is high at start, the block forces CPOL=0, CPHA=0, a 48-cycle setup, a divide-by-128 SCK and the configuration select `csN[2]`. `bootMode` also sets the SCK idle level to 0.
- R10: All settings are captured when the start is accepted. Changes to the settings while `busy` is high have no effect on the running transfer, and neither does a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| bootMode | input | 1 | Select the fixed EEPROM preset |
| csSel | input | 2 | Chip-select choice |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase |
| divExp | input | 4 | SCK divide exponent |
| setupCyc | input | 6 | Chip-select to first edge delay, in core cycles |
| byteCount | input | 8 | Number of bytes minus one |
| txByte | input | 8 | Next byte to send |
| txTake | output | 1 | Pulse: `txByte` was captured |
| rxByte | output | 8 | Last byte received |
| rxValid | output | 1 | Pulse: `rxByte` is new |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Pulse: transfer finished |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 3 | Chip selects, active low |

## Verification
Most internal faults show up at the pins quickly. A wrong tick limit or a wrong exponent decode changes the spacing between SCK edges, the setup gap or the hold gap on the very first transfer. A bad edge index or a bad phase decode corrupts the first byte that the slave model sees, and the first byte returned on `rxByte`. A byte counter that is off by one changes the number of edges and `txTake` pulses, and both are counted per transfer. A latch that leaks while busy shows up as a changed edge rate or a changed select line in the middle of a transfer.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  // Per-cycle commands from the sequencer to the shift datapath
  typedef struct packed {
    logic load;    // capture txByte into the transmit shifter
    logic shift;   // advance the transmit shifter by one bit
    logic sample;  // capture miso into the receive shifter
    logic push;    // present the completed receive byte
  } spiStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_HOLD,
    ST_GAP
  } spiState_t;

endpackage

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int EXP_W      = 4,
  parameter int MIN_EXP    = 3,
  parameter int MAX_EXP    = 14,
  parameter int SETUP_W    = 6,
  parameter int MIN_SETUP  = 16,
  parameter int MAX_SETUP  = 48,
  parameter int BOOT_EXP   = 7,
  parameter int BOOT_SETUP = 48,
  parameter int NUM_CS     = 3,
  parameter int GAP_CYC    = 2,
  localparam int SEL_W     = $clog2(NUM_CS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               bootMode,
  input  logic [SEL_W-1:0]   csSel,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [EXP_W-1:0]   divExp,
  input  logic [SETUP_W-1:0] setupCyc,
  input  logic [CNT_W-1:0]   byteCount,
  output spiStrobe_t         strobe,
  output logic               sck,
  output logic [NUM_CS-1:0]  csN,
  output logic               busy,
  output logic               done
);

  localparam int TICK_W = MAX_EXP - 1;
  localparam int EDGE_W = $clog2(2 * DATA_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);
  localparam logic [EDGE_W-1:0] PUSH_EDGE = EDGE_W'(2 * DATA_W - 2);

  spiState_t          state;
  logic [TICK_W-1:0]  tick;
  logic [EDGE_W-1:0]  edgeIdx;
  logic [CNT_W-1:0]   bytesLeft;
  logic               firstByte;
  logic               cfgCpha;
  logic [TICK_W-1:0]  cfgHalfLim;
  logic [TICK_W-1:0]  cfgSetupLim;

  // Effective settings: boot preset or clamped user fields
  logic               effCpol;
  logic               effCpha;
  logic [EXP_W-1:0]   effExp;
  logic [SETUP_W-1:0] effSetup;
  logic [SEL_W-1:0]   effCs;
  logic [TICK_W-1:0]  effHalfLim;
  logic [NUM_CS-1:0]  selLowN;

  always_comb begin
    if (bootMode) begin
      effCpol  = 1'b0;
      effCpha  = 1'b0;
      effExp   = EXP_W'(BOOT_EXP);
      effSetup = SETUP_W'(BOOT_SETUP);
      effCs    = SEL_W'(NUM_CS - 1);
    end else begin
      effCpol = cpol;
      effCpha = cpha;
      if (divExp < EXP_W'(MIN_EXP))      effExp = EXP_W'(MIN_EXP);
      else if (divExp > EXP_W'(MAX_EXP)) effExp = EXP_W'(MAX_EXP);
      else                               effExp = divExp;
      if (setupCyc < SETUP_W'(MIN_SETUP))      effSetup = SETUP_W'(MIN_SETUP);
      else if (setupCyc > SETUP_W'(MAX_SETUP)) effSetup = SETUP_W'(MAX_SETUP);
      else                                     effSetup = setupCyc;
      effCs = (csSel >= SEL_W'(NUM_CS - 1)) ? SEL_W'(NUM_CS - 1) : csSel;
    end
  end

  assign effHalfLim = TICK_W'((32'd1 << (effExp - EXP_W'(1))) - 32'd1);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csDec
    assign selLowN[i] = (effCs != SEL_W'(i));
  end

  // Edge scheduling
  logic accept, edgeNow, sampleEdge, byteEnd;

  assign accept     = (state == ST_IDLE) && start;
  assign edgeNow    = ((state == ST_SETUP) && (tick == cfgSetupLim)) ||
                      ((state == ST_XFER)  && (tick == cfgHalfLim));
  assign sampleEdge = cfgCpha ? edgeIdx[0] : ~edgeIdx[0];
  assign byteEnd    = (edgeIdx == LAST_EDGE);
  assign busy       = (state != ST_IDLE);

  always_comb begin
    strobe        = '0;
    strobe.load   = accept;
    strobe.sample = edgeNow && sampleEdge;
    strobe.push   = edgeNow && sampleEdge && (edgeIdx >= PUSH_EDGE);
    if (edgeNow && !sampleEdge) begin
      if (!cfgCpha) begin
        if (byteEnd) strobe.load  = (bytesLeft != '0);
        else         strobe.shift = 1'b1;
      end else begin
        if (edgeIdx == '0) strobe.load  = !firstByte;
        else               strobe.shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      tick        <= '0;
      edgeIdx     <= '0;
      bytesLeft   <= '0;
      firstByte   <= 1'b0;
      cfgCpha     <= 1'b0;
      cfgHalfLim  <= '0;
      cfgSetupLim <= '0;
      sck         <= 1'b0;
      csN         <= '1;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          sck <= effCpol;
          if (accept) begin
            state       <= ST_SETUP;
            tick        <= '0;
            edgeIdx     <= '0;
            bytesLeft   <= byteCount;
            firstByte   <= 1'b1;
            cfgCpha     <= effCpha;
            cfgHalfLim  <= effHalfLim;
            cfgSetupLim <= TICK_W'(effSetup) - TICK_W'(1);
            csN         <= selLowN;
          end
        end
        ST_SETUP, ST_XFER: begin
          tick <= tick + TICK_W'(1);
          if (edgeNow) begin
            sck     <= ~sck;
            tick    <= '0;
            edgeIdx <= edgeIdx + EDGE_W'(1);
            state   <= ST_XFER;
            if (byteEnd) begin
              if (bytesLeft == '0) begin
                state <= ST_HOLD;
              end else begin
                bytesLeft <= bytesLeft - CNT_W'(1);
                firstByte <= 1'b0;
              end
            end
          end
        end
        ST_HOLD: begin
          tick <= tick + TICK_W'(1);
          if (tick == cfgHalfLim) begin
            csN   <= '1;
            state <= ST_GAP;
            tick  <= '0;
          end
        end
        ST_GAP: begin
          tick <= tick + TICK_W'(1);
          if (tick == TICK_W'(GAP_CYC - 1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_xfer_dp.sv
module spi_xfer_dp
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        strobe,
  input  logic [DATA_W-1:0] txByte,
  input  logic              miso,
  output logic              mosi,
  output logic              txTake,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid
);

  logic [DATA_W-1:0] txSh;
  logic [DATA_W-1:0] rxSh;
  logic [DATA_W-1:0] rxNext;

  assign rxNext = {rxSh[DATA_W-2:0], miso};
  assign mosi   = txSh[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '0;
      rxSh    <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
      txTake  <= 1'b0;
    end else begin
      txTake  <= strobe.load;
      rxValid <= strobe.push;
      if (strobe.load)        txSh <= txByte;
      else if (strobe.shift)  txSh <= {txSh[DATA_W-2:0], 1'b0};
      if (strobe.sample)      rxSh <= rxNext;
      if (strobe.push)        rxByte <= rxNext;
    end
  end

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int EXP_W      = 4,
  parameter int MIN_EXP    = 3,
  parameter int MAX_EXP    = 14,
  parameter int SETUP_W    = 6,
  parameter int MIN_SETUP  = 16,
  parameter int MAX_SETUP  = 48,
  parameter int BOOT_EXP   = 7,
  parameter int BOOT_SETUP = 48,
  parameter int NUM_CS     = 3,
  parameter int GAP_CYC    = 2,
  localparam int SEL_W     = $clog2(NUM_CS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               bootMode,
  input  logic [SEL_W-1:0]   csSel,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [EXP_W-1:0]   divExp,
  input  logic [SETUP_W-1:0] setupCyc,
  input  logic [CNT_W-1:0]   byteCount,
  input  logic [DATA_W-1:0]  txByte,
  output logic               txTake,
  output logic [DATA_W-1:0]  rxByte,
  output logic               rxValid,
  output logic               busy,
  output logic               done,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_CS-1:0]  csN
);

  spiStrobe_t strobe;

  spi_xfer_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .EXP_W(EXP_W), .MIN_EXP(MIN_EXP),
    .MAX_EXP(MAX_EXP), .SETUP_W(SETUP_W), .MIN_SETUP(MIN_SETUP),
    .MAX_SETUP(MAX_SETUP), .BOOT_EXP(BOOT_EXP), .BOOT_SETUP(BOOT_SETUP),
    .NUM_CS(NUM_CS), .GAP_CYC(GAP_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .bootMode(bootMode),
    .csSel(csSel), .cpol(cpol), .cpha(cpha), .divExp(divExp),
    .setupCyc(setupCyc), .byteCount(byteCount), .strobe(strobe),
    .sck(sck), .csN(csN), .busy(busy), .done(done)
  );

  spi_xfer_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txByte(txByte),
    .miso(miso), .mosi(mosi), .txTake(txTake), .rxByte(rxByte),
    .rxValid(rxValid)
  );

endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk #(
  parameter int NUM_CS  = 3,
  parameter int GAP_CYC = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CS-1:0] csN,
  input logic              sck,
  input logic              busy,
  input logic              done,
  input logic              rxValid
);

  // Consecutive cycles with every select high, saturating
  logic [3:0] highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       highRun <= 4'hF;
    else if (csN != '1)              highRun <= 4'h0;
    else if (highRun != 4'hF)        highRun <= highRun + 4'h1;
  end

  AST_ONE_SELECT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1) else $error("two selects low"); // R6

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid) else $error("rxValid longer than one cycle"); // R5

  AST_RX_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (csN != '1)) else $error("byte returned with no select"); // R5

  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))) else $error("done misplaced"); // R8

  AST_SELECT_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (csN != '1) && ($past(csN) != '1)) |-> $stable(csN))
    else $error("select moved during transfer"); // R10

  AST_SCK_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (csN == '1)) |-> $stable(sck)) else $error("sck moved after release"); // R7

  AST_MIN_DESELECT_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (($past(csN) == '1) && (csN != '1)) |-> (highRun >= 4'(GAP_CYC)))
    else $error("deselect gap too short"); // R8

endmodule

bind spi_xfer_master spi_xfer_master_chk #(.NUM_CS(NUM_CS), .GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .busy(busy),
  .done(done), .rxValid(rxValid)
);

// File: tb/spi_xfer_master_tb.sv
module spi_xfer_master_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       bootMode = 1'b0;
  logic [1:0] csSel = 2'd0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic [3:0] divExp = 4'd3;
  logic [5:0] setupCyc = 6'd16;
  logic [7:0] byteCount = 8'd0;
  logic [7:0] txByte;
  logic       txTake;
  logic [7:0] rxByte;
  logic       rxValid;
  logic       busy;
  logic       done;
  logic       sck;
  logic       mosi;
  logic       miso = 1'b0;
  logic [2:0] csN;

  always #10 clk = ~clk;  // 50 MHz

  spi_xfer_master u_dut (
    .clk(clk), .rstN(rstN), .start(start), .bootMode(bootMode),
    .csSel(csSel), .cpol(cpol), .cpha(cpha), .divExp(divExp),
    .setupCyc(setupCyc), .byteCount(byteCount), .txByte(txByte),
    .txTake(txTake), .rxByte(rxByte), .rxValid(rxValid), .busy(busy),
    .done(done), .sck(sck), .mosi(mosi), .miso(miso), .csN(csN)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard state shared by the driver and the monitor
  logic [7:0] txArr [0:8];
  logic [7:0] respArr [0:8];
  logic [7:0] expTxQ [$];
  logic [7:0] expRxQ [$];
  int  nBytes = 1;
  bit  expCpha = 1'b0;

  int  takeCnt = 0, lastTake = 0, doneCnt = 0;
  int  cyc = 0, csFallCyc = 0, csRiseCyc = -100, lastEdgeCyc = 0;
  int  edgeCnt = 0, slvBits = 0, rxCnt = 0;
  int  setupMeas = 0, holdMeas = 0, gapMeas = 0, halfMin = 0, halfMax = 0;
  bit  prevCsLow = 1'b0, prevSck = 1'b0, sckAtFall = 1'b0, sckAtRise = 1'b0;
  logic [2:0] csAtFall = 3'b111;
  logic [7:0] slvSh = 8'h00;

  assign txByte = txArr[takeCnt];

  function automatic logic respBit(input int n);
    if (n / 8 >= nBytes) return 1'b0;
    return respArr[n / 8][7 - (n % 8)];
  endfunction

  // Monitor and slave model, all sampled away from the active edge
  always @(negedge clk) begin
    bit csLow, leading, sampleE;
    int d;
    cyc++;
    csLow = (csN != 3'b111);
    if (csLow && !prevCsLow) begin
      csFallCyc = cyc; gapMeas = cyc - csRiseCyc; sckAtFall = sck; csAtFall = csN;
      edgeCnt = 0; slvBits = 0; rxCnt = 0; halfMin = 1 << 30; halfMax = 0;
      if (!expCpha) miso = respBit(0);
    end
    if (!csLow && prevCsLow) begin
      csRiseCyc = cyc; holdMeas = cyc - lastEdgeCyc; sckAtRise = sck;
    end
    if (csLow && prevCsLow && (sck != prevSck)) begin
      if (edgeCnt == 0) setupMeas = cyc - csFallCyc;
      else begin
        d = cyc - lastEdgeCyc;
        if (d < halfMin) halfMin = d;
        if (d > halfMax) halfMax = d;
      end
      leading = (edgeCnt % 2 == 0);
      sampleE = expCpha ? !leading : leading;
      if (sampleE) begin
        slvSh = {slvSh[6:0], mosi};
        slvBits++;
        if (slvBits % 8 == 0) begin
          if (expTxQ.size() > 0) begin
            logic [7:0] e;
            e = expTxQ.pop_front();
            check(slvSh == e, "R4", "byte seen by slave", slvSh, e);
          end else check(1'b0, "R4", "unexpected slave byte", slvSh, 0);
        end
      end else begin
        miso = respBit(slvBits);
      end
      edgeCnt++;
      lastEdgeCyc = cyc;
    end
    if (rxValid) begin
      rxCnt++;
      if (expRxQ.size() > 0) begin
        logic [7:0] e;
        e = expRxQ.pop_front();
        check(rxByte == e, "R5", "rxByte", rxByte, e);
      end else check(1'b0, "R5", "unexpected rxValid", rxByte, 0);
    end
    if (txTake) takeCnt++;
    if (done) begin doneCnt++; lastTake = takeCnt; takeCnt = 0; end
    prevCsLow = csLow;
    prevSck = sck;
  end

  // Driver: sets up one transfer, queues expectations, checks timing at end
  task automatic xfer(input bit boot, input logic [1:0] sel, input bit pol,
                      input bit pha, input int ex, input int su, input int n,
                      input int seed, input bit disturb, input bit quick);
    int eH, eS, eCs, d0;
    bit eCpol;
    if (boot) begin
      eCpol = 0; expCpha = 0; eH = 64; eS = 48; eCs = 2;
    end else begin
      int ce, cs2;
      ce  = (ex < 3) ? 3 : (ex > 14) ? 14 : ex;
      cs2 = (su < 16) ? 16 : (su > 48) ? 48 : su;
      eCpol = pol; expCpha = pha; eH = 1 << (ce - 1); eS = cs2;
      eCs = (sel >= 2) ? 2 : int'(sel);
    end
    nBytes = n;
    for (int i = 0; i < n; i++) begin
      txArr[i]   = 8'((seed * 37 + i * 91 + 5) & 255);
      respArr[i] = 8'((seed * 53 + i * 29 + 170) & 255);
      expTxQ.push_back(txArr[i]);
      expRxQ.push_back(respArr[i]);
    end
    bootMode = boot; csSel = sel; cpol = pol; cpha = pha;
    divExp = 4'(ex); setupCyc = 6'(su); byteCount = 8'(n - 1);
    if (!quick) repeat (3) @(negedge clk);
    d0 = doneCnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (12) @(negedge clk);
      cpol = ~pol; cpha = ~pha; divExp = 4'd4; setupCyc = 6'd40;
      csSel = sel + 2'd1; byteCount = 8'd5; bootMode = ~boot;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (doneCnt != d0);
    check(busy == 1'b0, "R8", "busy after done", busy, 0);
    check(doneCnt == d0 + 1, "R8", "done pulses", doneCnt - d0, 1);
    check(setupMeas == eS, boot ? "R9" : "R2", "setup cycles", setupMeas, eS);
    check(halfMin == eH && halfMax == eH, boot ? "R9" : "R1", "half period",
          (halfMin == eH) ? halfMax : halfMin, eH);
    check(sckAtFall == eCpol && sckAtRise == eCpol, "R3", "sck idle level",
          sckAtFall, eCpol);
    check(csAtFall == ~(3'b001 << eCs), "R6", "select line", csAtFall, ~(3'b001 << eCs));
    check(edgeCnt == 16 * n, disturb ? "R10" : "R4", "sck edges", edgeCnt, 16 * n);
    check(lastTake == n, disturb ? "R10" : "R4", "txTake pulses", lastTake, n);
    check(rxCnt == n, "R5", "rxValid pulses", rxCnt, n);
    check(holdMeas == eH, "R7", "hold after last edge", holdMeas, eH);
    check(expTxQ.size() == 0 && expRxQ.size() == 0, "R4", "scoreboard drained",
          expTxQ.size() + expRxQ.size(), 0);
    if (quick) check(gapMeas >= 2, "R8", "deselect gap", gapMeas, 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) begin txArr[i] = 8'h00; respArr[i] = 8'h00; end
    repeat (4) @(negedge clk);
    check(csN == 3'b111, "R6", "reset selects", csN, 7);
    check(busy == 1'b0 && done == 1'b0, "R8", "reset busy/done", {busy, done}, 0);
    check(rxValid == 1'b0, "R5", "reset rxValid", rxValid, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    xfer(0, 2'd0, 0, 0, 3, 16, 1, 1, 0, 0);   // mode 0, fastest
    xfer(0, 2'd1, 0, 1, 4, 20, 3, 2, 0, 0);   // mode 1
    xfer(0, 2'd2, 1, 0, 5, 48, 2, 3, 0, 0);   // mode 2
    xfer(0, 2'd3, 1, 1, 2, 5, 2, 4, 0, 0);    // mode 3, both lower clamps, sel 3
    xfer(0, 2'd1, 0, 0, 6, 60, 1, 5, 0, 0);   // setup upper clamp
    xfer(1, 2'd0, 1, 1, 3, 16, 2, 6, 0, 0);   // boot preset overrides
    xfer(0, 2'd0, 1, 0, 3, 17, 2, 7, 1, 0);   // R10 changes while busy
    xfer(0, 2'd2, 0, 1, 3, 16, 1, 8, 0, 1);   // back-to-back, R8 gap
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule